// File: doc/BRIEF.md
# Dual Quadrature Resonant Filter with Sequence Separation

This block is a fixed-point, sample-driven datapath for a grid-synchronisation front end. It accepts the two stationary-frame voltage components (alpha and beta) and a normalised centre-frequency step. Each axis has its own second-order generalised-integrator resonator. The resonator yields a band-pass "direct" copy of its input and a copy that lags by a quarter period. A cross-axis combiner then turns the four filtered signals into the positive-sequence alpha/beta pair. It can also form the negative-sequence pair.

The centre frequency is a port. An outer tracking loop, which is not part of this block, can retune it on every sample. The datapath advances by exactly one forward-Euler step on each cycle where `step_i` is high. It holds its state in all other cycles. `valid_o` marks the cycle in which the results of a step appear.

`theta_i` carries w·Ts as an unsigned fraction with 16 fractional bits. For example, 50 Hz at a 10 kHz sample rate is 2059 and 60 Hz is 2471. The damping gain k is a parameter with 6 fractional bits. Its default value of 2 is coded as 128. Samples are signed two's-complement values of `DATA_W` bits. The internal state carries `EXT_W` extra fraction bits.

Top module: `dsogi_pse`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, every data output and `valid_o` is zero.
- R2: State changes only on a cycle where `step_i` is high. With `step_i` low, every data output keeps its value.
- R3: `valid_o` is high in exactly the cycle that follows a cycle with `step_i` high, and low otherwise.
- R4: Each axis updates with forward Euler using the old state. The update uses the following quantities:
  - ve = v<<EXT_W and e = ve − d.
  - u = sat((e·K)>>>K_FRAC − q).
  - d' = sat(d + (u·θ)>>>16).
  - q' = sat(q + (d·θ)>>>16).

  All shifts are arithmetic (they round toward minus infinity). `*_d_o` and `*_q_o` are the state >>> EXT_W.
- R5: The state saturates at the signed full scale of DATA_W+EXT_W bits and never wraps. With a constant +32767 input, `alpha_q_o` settles at exactly 32767.
- R6: `pos_alpha_o` = (d_α − q_β)>>>(EXT_W+1) and `pos_beta_o` = (q_α + d_β)>>>(EXT_W+1), both taken on the full-width state.
- R7: `neg_alpha_o` = (d_α + q_β)>>>(EXT_W+1) and `neg_beta_o` = (d_β − q_α)>>>(EXT_W+1). When NEG_EN is 0, both outputs are held at zero.
- R8: A step taken with `theta_i` = 0 leaves every data output unchanged.
- R9: Apply a balanced positive-sequence input (α = A·cos, β = A·sin) at the centre frequency, and allow it to settle. The positive outputs then track α and β within 7.5 % of A. The negative outputs stay within that bound of zero. `alpha_q_o` tracks A·sin, which is α delayed by 90°.
- R10: Apply a negative-sequence input (β = −A·sin), and allow it to settle. The positive outputs then stay near zero and `neg_alpha_o` tracks α, within the same bound.
- R11: Retuning `theta_i` to 60 Hz makes the filter track a 60 Hz positive-sequence input within the same bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Sample strobe; one Euler step per high cycle |
| v_alpha_i | input | DATA_W | Alpha-axis input sample, signed |
| v_beta_i | input | DATA_W | Beta-axis input sample, signed |
| theta_i | input | TH_W | Centre frequency as w·Ts, unsigned, TH_W fraction bits |
| valid_o | output | 1 | High the cycle after a strobe |
| alpha_d_o | output | DATA_W | Alpha direct (band-pass) output |
| alpha_q_o | output | DATA_W | Alpha quadrature (lagging) output |
| beta_d_o | output | DATA_W | Beta direct output |
| beta_q_o | output | DATA_W | Beta quadrature output |
| pos_alpha_o | output | DATA_W | Positive-sequence alpha |
| pos_beta_o | output | DATA_W | Positive-sequence beta |
| neg_alpha_o | output | DATA_W | Negative-sequence alpha (zero if NEG_EN=0) |
| neg_beta_o | output | DATA_W | Negative-sequence beta (zero if NEG_EN=0) |

## Verification
The bench builds the block with its default parameters: DATA_W=16, EXT_W=8, TH_W=16, K_GAIN=128 with K_FRAC=6, and NEG_EN=1. Because EXT_W is 8 and the shift is floor-based, the outputs of the first two steps can be predicted to the last bit. A small vector table pins down the Euler recurrence and the signs of both sequence combiners, including the floor on negative values. A large θ together with a full-scale DC input drives q into saturation within a few hundred steps. Sine runs of several thousand samples at 50 Hz and 60 Hz reach steady state, so the quarter-period lag and the sequence separation can be checked against tolerance bounds.

// File: rtl/dsogi_pkg.sv
package dsogi_pkg;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned EXT_W_DEF  = 8;
  localparam int unsigned TH_W_DEF   = 16;
  localparam int unsigned K_W_DEF    = 8;
  localparam int unsigned K_FRAC_DEF = 6;
  localparam int unsigned K_GAIN_DEF = 128;  // k = 2.0
  localparam int unsigned N_AXES     = 2;
  typedef enum logic {AX_ALPHA = 1'b0, AX_BETA = 1'b1} axis_e;
endpackage

// File: rtl/dsogi_axis.sv
module dsogi_axis #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned TH_W   = 16,
  parameter int unsigned K_W    = 8,
  parameter int unsigned K_FRAC = 6,
  parameter int unsigned K_GAIN = 128,
  localparam int unsigned SW    = DATA_W + EXT_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic signed [DATA_W-1:0] v_i,
  input  logic        [TH_W-1:0]   theta_i,
  output logic signed [SW-1:0]     d_o,
  output logic signed [SW-1:0]     q_o
);
  localparam int unsigned WW = SW + K_W + TH_W + 4;
  localparam logic signed [WW-1:0] S_MAX = {{(WW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [WW-1:0] S_MIN = {{(WW-SW+1){1'b1}}, {(SW-1){1'b0}}};
  localparam logic signed [WW-1:0] K_W_S = WW'(K_GAIN);

  function automatic logic signed [SW-1:0] clamp(input logic signed [WW-1:0] x);
    if (x > S_MAX)      return S_MAX[SW-1:0];
    else if (x < S_MIN) return S_MIN[SW-1:0];
    else                return x[SW-1:0];
  endfunction

  logic signed [SW-1:0] d_q, q_q, d_n, q_n, u;
  logic signed [WW-1:0] v_w, e_w, ke_w, th_w, dd_w, dq_w;

  always_comb begin
    v_w  = WW'(v_i) <<< EXT_W;
    e_w  = v_w - WW'(d_q);
    ke_w = (e_w * K_W_S) >>> K_FRAC;
    u    = clamp(ke_w - WW'(q_q));
    th_w = signed'(WW'(theta_i));
    dd_w = (WW'(u) * th_w) >>> TH_W;
    dq_w = (WW'(d_q) * th_w) >>> TH_W;   // forward Euler: old d feeds q
    d_n  = clamp(WW'(d_q) + dd_w);
    q_n  = clamp(WW'(q_q) + dq_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      q_q <= '0;
    end else if (step_i) begin
      d_q <= d_n;
      q_q <= q_n;
    end
  end

  assign d_o = d_q;
  assign q_o = q_q;
endmodule

// File: rtl/dsogi_seq.sv
module dsogi_seq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned EXT_W  = 8,
  parameter bit          NEG_EN = 1'b1,
  localparam int unsigned SW    = DATA_W + EXT_W
) (
  input  logic signed [SW-1:0]     da_i,
  input  logic signed [SW-1:0]     qa_i,
  input  logic signed [SW-1:0]     db_i,
  input  logic signed [SW-1:0]     qb_i,
  output logic signed [DATA_W-1:0] pa_o,
  output logic signed [DATA_W-1:0] pb_o,
  output logic signed [DATA_W-1:0] na_o,
  output logic signed [DATA_W-1:0] nb_o
);
  logic signed [SW:0] pa_s, pb_s;
  assign pa_s = (SW+1)'(da_i) - (SW+1)'(qb_i);
  assign pb_s = (SW+1)'(qa_i) + (SW+1)'(db_i);
  assign pa_o = pa_s[SW:EXT_W+1];
  assign pb_o = pb_s[SW:EXT_W+1];

  if (NEG_EN) begin : g_neg
    logic signed [SW:0] na_s, nb_s;
    assign na_s = (SW+1)'(da_i) + (SW+1)'(qb_i);
    assign nb_s = (SW+1)'(db_i) - (SW+1)'(qa_i);
    assign na_o = na_s[SW:EXT_W+1];
    assign nb_o = nb_s[SW:EXT_W+1];
  end else begin : g_no_neg
    assign na_o = '0;
    assign nb_o = '0;
  end
endmodule

// File: rtl/dsogi_pse.sv
module dsogi_pse
  import dsogi_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned EXT_W  = EXT_W_DEF,
  parameter int unsigned TH_W   = TH_W_DEF,
  parameter int unsigned K_W    = K_W_DEF,
  parameter int unsigned K_FRAC = K_FRAC_DEF,
  parameter int unsigned K_GAIN = K_GAIN_DEF,
  parameter bit          NEG_EN = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic signed [DATA_W-1:0] v_alpha_i,
  input  logic signed [DATA_W-1:0] v_beta_i,
  input  logic        [TH_W-1:0]   theta_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] alpha_d_o,
  output logic signed [DATA_W-1:0] alpha_q_o,
  output logic signed [DATA_W-1:0] beta_d_o,
  output logic signed [DATA_W-1:0] beta_q_o,
  output logic signed [DATA_W-1:0] pos_alpha_o,
  output logic signed [DATA_W-1:0] pos_beta_o,
  output logic signed [DATA_W-1:0] neg_alpha_o,
  output logic signed [DATA_W-1:0] neg_beta_o
);
  localparam int unsigned SW = DATA_W + EXT_W;

  logic signed [DATA_W-1:0] v_ax [N_AXES];
  logic signed [SW-1:0]     d_ax [N_AXES];
  logic signed [SW-1:0]     q_ax [N_AXES];

  assign v_ax[AX_ALPHA] = v_alpha_i;
  assign v_ax[AX_BETA]  = v_beta_i;

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    dsogi_axis #(
      .DATA_W(DATA_W), .EXT_W(EXT_W), .TH_W(TH_W),
      .K_W(K_W), .K_FRAC(K_FRAC), .K_GAIN(K_GAIN)
    ) u_axis (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (step_i),
      .v_i     (v_ax[g]),
      .theta_i (theta_i),
      .d_o     (d_ax[g]),
      .q_o     (q_ax[g])
    );
  end

  dsogi_seq #(.DATA_W(DATA_W), .EXT_W(EXT_W), .NEG_EN(NEG_EN)) u_seq (
    .da_i (d_ax[AX_ALPHA]),
    .qa_i (q_ax[AX_ALPHA]),
    .db_i (d_ax[AX_BETA]),
    .qb_i (q_ax[AX_BETA]),
    .pa_o (pos_alpha_o),
    .pb_o (pos_beta_o),
    .na_o (neg_alpha_o),
    .nb_o (neg_beta_o)
  );

  assign alpha_d_o = d_ax[AX_ALPHA][SW-1:EXT_W];
  assign alpha_q_o = q_ax[AX_ALPHA][SW-1:EXT_W];
  assign beta_d_o  = d_ax[AX_BETA][SW-1:EXT_W];
  assign beta_q_o  = q_ax[AX_BETA][SW-1:EXT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= step_i;
  end
endmodule

// File: rtl/dsogi_pse_chk.sv
module dsogi_pse_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TH_W   = 16,
  parameter bit          NEG_EN = 1'b1
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     step_i,
  input logic        [TH_W-1:0]   theta_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] alpha_d_o,
  input logic signed [DATA_W-1:0] alpha_q_o,
  input logic signed [DATA_W-1:0] beta_d_o,
  input logic signed [DATA_W-1:0] beta_q_o,
  input logic signed [DATA_W-1:0] pos_alpha_o,
  input logic signed [DATA_W-1:0] pos_beta_o,
  input logic signed [DATA_W-1:0] neg_alpha_o,
  input logic signed [DATA_W-1:0] neg_beta_o
);
  p_valid_after_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> valid_o);

  p_valid_only_after_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !valid_o);

  p_hold_no_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(alpha_d_o) && $stable(alpha_q_o) && $stable(beta_d_o)
                 && $stable(beta_q_o) && $stable(pos_alpha_o) && $stable(pos_beta_o)));

  p_freeze_theta0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && theta_i == '0) |=> ($stable(alpha_d_o) && $stable(alpha_q_o)
                                   && $stable(beta_d_o) && $stable(beta_q_o)));

  if (NEG_EN) begin : g_sum
    // pos + neg recombines the direct output (R6, R7), floor error at most 1
    p_alpha_sum_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((int'(pos_alpha_o) + int'(neg_alpha_o) - int'(alpha_d_o)) inside {-1, 0, 1}));
    p_beta_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((int'(pos_beta_o) + int'(neg_beta_o) - int'(beta_d_o)) inside {-1, 0, 1}));
  end else begin : g_zero
    p_neg_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (neg_alpha_o == '0 && neg_beta_o == '0));
  end
endmodule

bind dsogi_pse dsogi_pse_chk #(.DATA_W(DATA_W), .TH_W(TH_W), .NEG_EN(NEG_EN)) u_chk (.*);

// File: tb/tb_dsogi_pse.sv
module tb_dsogi_pse;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TW = 16;
  localparam real PI = 3.14159265358979;

  // va, vb, theta, exp: ad, aq, bd, bq, pa, pb, na, nb  (R4, R6, R7)
  localparam int NV = 2;
  localparam int VEC [NV][11] = '{
    '{1000, -1000, 2059, 62, 0, -63, 0, 31, -32, 31, -32},
    '{1000, -1000, 2059, 121, 1, -122, -2, 61, -60, 59, -62}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, step_i = 1'b0;
  logic signed [DW-1:0] v_alpha_i = '0, v_beta_i = '0;
  logic [TW-1:0] theta_i = '0;
  logic valid_o;
  logic signed [DW-1:0] alpha_d_o, alpha_q_o, beta_d_o, beta_q_o;
  logic signed [DW-1:0] pos_alpha_o, pos_beta_o, neg_alpha_o, neg_beta_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dsogi_pse dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_le(string req, int act, int bound);
    n_chk++;
    if (act > bound) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected<=%0d", req, act, bound);
    end
  endtask

  task automatic step(int va, int vb, int th);
    @(negedge clk_i);
    v_alpha_i = DW'(va); v_beta_i = DW'(vb); theta_i = TW'(th);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  // run a sine test; mode 0: positive sequence, 1: negative sequence
  task automatic sine_run(string req, int th, real f, bit neg_seq);
    int amp = 16000;
    int tol = 1200;
    int e_pa = 0, e_pb = 0, e_n = 0, e_q = 0;
    for (int n = 0; n < 3200; n++) begin
      real ph;
      int ca, sb;
      ph = 2.0 * PI * f * real'(n) / 10000.0;
      ca = int'(real'(amp) * $cos(ph));
      sb = int'(real'(amp) * $sin(ph));
      step(ca, neg_seq ? -sb : sb, th);
      if (n >= 3000) begin
        if (!neg_seq) begin
          e_pa = (iabs(int'(pos_alpha_o) - ca) > e_pa) ? iabs(int'(pos_alpha_o) - ca) : e_pa;
          e_pb = (iabs(int'(pos_beta_o) - sb) > e_pb) ? iabs(int'(pos_beta_o) - sb) : e_pb;
          e_n  = (iabs(int'(neg_alpha_o)) > e_n) ? iabs(int'(neg_alpha_o)) : e_n;
          e_q  = (iabs(int'(alpha_q_o) - sb) > e_q) ? iabs(int'(alpha_q_o) - sb) : e_q;
        end else begin
          e_pa = (iabs(int'(neg_alpha_o) - ca) > e_pa) ? iabs(int'(neg_alpha_o) - ca) : e_pa;
          e_pb = (iabs(int'(neg_beta_o) + sb) > e_pb) ? iabs(int'(neg_beta_o) + sb) : e_pb;
          e_n  = (iabs(int'(pos_alpha_o)) > e_n) ? iabs(int'(pos_alpha_o)) : e_n;
          e_q  = (iabs(int'(pos_beta_o)) > e_q) ? iabs(int'(pos_beta_o)) : e_q;
        end
      end
    end
    chk_le({req, " track alpha"}, e_pa, tol);
    chk_le({req, " track beta"}, e_pb, tol);
    chk_le({req, " opposite seq alpha ~0"}, e_n, tol);
    chk_le({req, neg_seq ? " opposite seq beta ~0" : " quadrature lag"}, e_q, tol);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 pos_alpha in reset", int'(pos_alpha_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 alpha_d after reset", int'(alpha_d_o), 0);
    chk("R1 beta_q after reset", int'(beta_q_o), 0);
    chk("R1 neg_beta after reset", int'(neg_beta_o), 0);

    // R4 R6 R7: exact first steps from the table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][0], VEC[i][1], VEC[i][2]);
      chk("R3 valid after step", int'(valid_o), 1);
      chk("R4 alpha_d", int'(alpha_d_o), VEC[i][3]);
      chk("R4 alpha_q", int'(alpha_q_o), VEC[i][4]);
      chk("R4 beta_d",  int'(beta_d_o),  VEC[i][5]);
      chk("R4 beta_q",  int'(beta_q_o),  VEC[i][6]);
      chk("R6 pos_alpha", int'(pos_alpha_o), VEC[i][7]);
      chk("R6 pos_beta",  int'(pos_beta_o),  VEC[i][8]);
      chk("R7 neg_alpha", int'(neg_alpha_o), VEC[i][9]);
      chk("R7 neg_beta",  int'(neg_beta_o),  VEC[i][10]);
    end

    // R3: valid drops the cycle after
    @(negedge clk_i);
    chk("R3 valid low without step", int'(valid_o), 0);

    // R2: inputs move, no strobe, outputs hold
    v_alpha_i = 16'sd20000; v_beta_i = -16'sd20000; theta_i = 16'd30000;
    repeat (20) @(negedge clk_i);
    chk("R2 alpha_d held", int'(alpha_d_o), 121);
    chk("R2 beta_q held", int'(beta_q_o), -2);

    // R8: theta zero freezes state
    step(30000, -30000, 0);
    chk("R8 alpha_d frozen", int'(alpha_d_o), 121);
    chk("R8 alpha_q frozen", int'(alpha_q_o), 1);
    chk("R8 neg_beta frozen", int'(neg_beta_o), -62);

    // R5: saturation with full-scale DC
    do_reset();
    for (int n = 0; n < 400; n++) step(32767, 0, 20000);
    chk("R5 alpha_q saturates", int'(alpha_q_o), 32767);
    chk("R5 pos_beta no wrap", int'(pos_beta_o), 16383);

    // R9 R10 R11: sine tracking
    do_reset();
    sine_run("R9", 2059, 50.0, 1'b0);
    sine_run("R10", 2059, 50.0, 1'b1);
    sine_run("R11", 2471, 60.0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule